// File: doc/BRIEF.md
# FIFO Level Watcher

This block watches the fill state of a peripheral's receive and transmit FIFOs and turns it into two kinds of signal. The first kind is a pair of threshold flags. Each flag compares a FIFO count with an 8-bit limit set by software, and the flags can be routed to a single interrupt line through per-flag enables. The second kind is a pair of DMA requests. These follow only whether the FIFO holds data or has room, and never look at the limits.

The receive side takes the number of occupied entries and the transmit side takes the number of free entries. The same rule applies to both sides: a flag is raised when its count is strictly greater than its limit. A limit of zero therefore raises the receive flag as soon as one word is waiting, and raises the transmit flag as soon as one slot is open. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge. The FIFO storage, its pointers and the register decoding that supplies the limits and enables live outside this block.

Top module: `fifo_level_watch`

## Requirements
- R1: While the active-low reset is asserted, and at the first clock edge after it is released, all five outputs are 0.
- R2: One clock edge after the inputs are sampled, `rx_lvl_hit` is 1 exactly when the unsigned value of `rx_used` is strictly greater than the unsigned value of `rx_limit`. Example: a limit of 0 with 1 entry gives 1, and a limit of 5 with 5 entries gives 0.
- R3: One clock edge after sampling, `tx_lvl_hit` is 1 exactly when the unsigned value of `tx_free` is strictly greater than the unsigned value of `tx_limit`. Example: a limit of 0 with 1 free slot gives 1.
- R4: One clock edge after sampling, `rx_dma_req` is 1 exactly when `rx_used` is non-zero, whatever the value of `rx_limit`.
- R5: One clock edge after sampling, `tx_dma_req` is 1 exactly when `tx_free` is non-zero, whatever the value of `tx_limit`.
- R6: One clock edge after sampling, `irq` equals the receive condition of R2 ANDed with `rx_irq_en`, ORed with the transmit condition of R3 ANDed with `tx_irq_en`.
- R7: A cleared enable masks only the interrupt. The matching `*_lvl_hit` flag still reports its condition, and the other channel still drives `irq`.
- R8: The full count range is handled. With DEPTH = 256, a count of 256 against a limit of 255 raises the flag, and a count of 255 against a limit of 255 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_used | input | CNT_W (9) | Occupied entries in the receive FIFO, 0..DEPTH |
| tx_free | input | CNT_W (9) | Free entries in the transmit FIFO, 0..DEPTH |
| rx_limit | input | 8 | Receive threshold value |
| tx_limit | input | 8 | Transmit threshold value |
| rx_irq_en | input | 1 | Routes the receive flag to `irq` |
| tx_irq_en | input | 1 | Routes the transmit flag to `irq` |
| rx_lvl_hit | output | 1 | Receive threshold reached |
| tx_lvl_hit | output | 1 | Transmit threshold reached |
| rx_dma_req | output | 1 | Receive FIFO holds data |
| tx_dma_req | output | 1 | Transmit FIFO has room |
| irq | output | 1 | Combined enabled threshold interrupt |

## Verification
The only internal state is the output register, so a wrong comparison or a wrong mask appears at the ports on the very next clock edge. An error at the equality boundary, such as testing greater-or-equal instead of greater, shows up only when the count equals the limit. The same holds at the widest count, where a truncated comparison would drop the ninth bit. A DMA request that depends on the limit by mistake shows up when a non-zero count sits below a large limit. Every stimulus is therefore checked one cycle after it is applied, with explicit equality and extreme-count cases, followed by a random sweep.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

    // Channel indices used by the generate loop.
    localparam int CH_RX = 0;
    localparam int CH_TX = 1;
    localparam int N_CH  = 2;

    // The full set of registered outputs.
    typedef struct packed {
        logic rx_hit;
        logic tx_hit;
        logic rx_dma;
        logic tx_dma;
        logic irq;
    } lvl_state_t;

endpackage

// File: rtl/fifo_lvl_cmp.sv
// Compares one count with one limit, both unsigned.
// Also reports whether the count is non-zero.
module fifo_lvl_cmp #(
    parameter int CNT_W = 9,
    parameter int LIM_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [LIM_W-1:0] limit,
    output logic             above,
    output logic             nonzero
);
    // Both operands are widened to a common width so the compare is
    // lossless whichever of the two is wider.
    localparam int CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        cnt_ext = CMP_W'(count);
        lim_ext = CMP_W'(limit);
        above   = cnt_ext > lim_ext;
        nonzero = |count;
    end
endmodule

// File: rtl/fifo_level_watch.sv
module fifo_level_watch
    import fifo_lvl_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LIM_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_used,
    input  logic [CNT_W-1:0] tx_free,
    input  logic [LIM_W-1:0] rx_limit,
    input  logic [LIM_W-1:0] tx_limit,
    input  logic             rx_irq_en,
    input  logic             tx_irq_en,
    output logic             rx_lvl_hit,
    output logic             tx_lvl_hit,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             irq
);

    logic [CNT_W-1:0] cnt_arr [N_CH];
    logic [LIM_W-1:0] lim_arr [N_CH];
    logic [N_CH-1:0]  above_vec;
    logic [N_CH-1:0]  nz_vec;
    logic [N_CH-1:0]  en_vec;

    always_comb begin
        cnt_arr[CH_RX] = rx_used;
        cnt_arr[CH_TX] = tx_free;
        lim_arr[CH_RX] = rx_limit;
        lim_arr[CH_TX] = tx_limit;
        en_vec[CH_RX]  = rx_irq_en;
        en_vec[CH_TX]  = tx_irq_en;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        fifo_lvl_cmp #(
            .CNT_W (CNT_W),
            .LIM_W (LIM_W)
        ) u_cmp (
            .count   (cnt_arr[ch]),
            .limit   (lim_arr[ch]),
            .above   (above_vec[ch]),
            .nonzero (nz_vec[ch])
        );
    end

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rx_hit = above_vec[CH_RX];
        st_d.tx_hit = above_vec[CH_TX];
        st_d.rx_dma = nz_vec[CH_RX];
        st_d.tx_dma = nz_vec[CH_TX];
        st_d.irq    = |(above_vec & en_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_lvl_hit = st_q.rx_hit;
    assign tx_lvl_hit = st_q.tx_hit;
    assign rx_dma_req = st_q.rx_dma;
    assign tx_dma_req = st_q.tx_dma;
    assign irq        = st_q.irq;

    AST_RX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_lvl_hit == ($past(32'(rx_used)) > $past(32'(rx_limit))))); // R2
    AST_TX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tx_lvl_hit == ($past(32'(tx_free)) > $past(32'(tx_limit))))); // R3
    AST_RX_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_dma_req == ($past(rx_used) != '0))); // R4
    AST_TX_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tx_dma_req == ($past(tx_free) != '0))); // R5
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == ((rx_lvl_hit && $past(rx_irq_en)) ||
                                  (tx_lvl_hit && $past(tx_irq_en))))); // R6
    AST_DMA_BELOW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl_hit |-> rx_dma_req); // R4

endmodule

// File: tb/fifo_level_watch_test.sv
module fifo_level_watch_test;
    localparam int DEPTH = 256;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct {
        logic  rx_hit, tx_hit, rx_dma, tx_dma, irq;
        string tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic [CNT_W-1:0] rx_used = '0, tx_free = '0;
    logic [7:0] rx_limit = '0, tx_limit = '0;
    logic rx_irq_en = 0, tx_irq_en = 0;
    logic rx_lvl_hit, tx_lvl_hit, rx_dma_req, tx_dma_req, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    exp_t sb [$];

    always #10 clk = ~clk;

    fifo_level_watch #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_used(rx_used), .tx_free(tx_free),
        .rx_limit(rx_limit), .tx_limit(tx_limit),
        .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
        .rx_lvl_hit(rx_lvl_hit), .tx_lvl_hit(tx_lvl_hit),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req), .irq(irq));

    task automatic check(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    // Driver: applies one stimulus and queues the expected result.
    task automatic apply(input int ru, input int tf, input int rl, input int tl,
                         input bit re, input bit te, input string tag);
        exp_t e;
        @(negedge clk);
        rx_used = CNT_W'(ru); tx_free = CNT_W'(tf);
        rx_limit = 8'(rl); tx_limit = 8'(tl);
        rx_irq_en = re; tx_irq_en = te;
        e.rx_hit = ru > rl;
        e.tx_hit = tf > tl;
        e.rx_dma = ru != 0;
        e.tx_dma = tf != 0;
        e.irq    = (e.rx_hit && re) || (e.tx_hit && te);
        e.tag    = tag;
        sb.push_back(e);
    endtask

    // Monitor: one edge after each stimulus, compares all outputs.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(rx_lvl_hit, e.rx_hit, {"R2 rx_lvl_hit ", e.tag});
                check(tx_lvl_hit, e.tx_hit, {"R3 tx_lvl_hit ", e.tag});
                check(rx_dma_req, e.rx_dma, {"R4 rx_dma_req ", e.tag});
                check(tx_dma_req, e.tx_dma, {"R5 tx_dma_req ", e.tag});
                check(irq,        e.irq,    {"R6 irq ", e.tag});
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state with non-zero inputs present
        rx_used = 9'd7; tx_free = 9'd7; rx_irq_en = 1; tx_irq_en = 1;
        repeat (3) @(posedge clk);
        #5;
        check(rx_lvl_hit, 0, "R1 rx_lvl_hit in reset");
        check(tx_lvl_hit, 0, "R1 tx_lvl_hit in reset");
        check(rx_dma_req, 0, "R1 rx_dma_req in reset");
        check(tx_dma_req, 0, "R1 tx_dma_req in reset");
        check(irq,        0, "R1 irq in reset");
        @(negedge clk);
        rx_used = '0; tx_free = '0;
        rst_n = 1;

        apply(0, 0, 0, 0, 1, 1, "empty");
        apply(1, 0, 0, 0, 1, 1, "rx one entry limit 0");
        apply(0, 1, 0, 0, 1, 1, "tx one free limit 0");
        apply(5, 5, 5, 5, 1, 1, "equal not above");
        apply(6, 6, 5, 5, 1, 1, "one above");
        apply(3, 3, 200, 200, 1, 1, "R4 R5 dma ignores limit");
        // R7: masked enable keeps flag visible
        apply(9, 0, 2, 0, 0, 1, "R7 rx masked");
        apply(9, 9, 2, 2, 0, 1, "R7 tx still drives irq");
        apply(0, 9, 0, 2, 1, 0, "R7 tx masked");
        // R8: widest counts
        apply(256, 256, 255, 255, 1, 1, "R8 full above 255");
        apply(255, 255, 255, 255, 1, 1, "R8 255 equal");
        apply(256, 0, 0, 255, 1, 1, "R8 full rx empty tx");
        for (int i = 0; i < 300; i++) begin
            apply($urandom_range(0, DEPTH), $urandom_range(0, DEPTH),
                  $urandom_range(0, 255), $urandom_range(0, 255),
                  1'($urandom), 1'($urandom), "random");
        end
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule